// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is a serial slave port that gives a host access to a small bank of byte-wide control registers. A transaction opens when chip select falls. It begins with a 16-bit instruction word that carries a read/write flag and a start address. Data bytes follow, and each data byte moves the working address one step, so a single transaction can stream any number of bytes. The transaction ends when chip select rises.

A configuration byte at address 0 sets the order in which bits travel on the serial line and the direction in which the address steps. Each setting has two copies inside that byte. The same byte holds a self-clearing soft reset. The soft reset returns every register to its default and then holds the port busy for a fixed boot interval, during which writes are dropped. The rest of the bank holds a datapath reset strobe, a two-bit channel power mode and three read-only identity bytes. The power mode and the datapath strobe leave the block as output pins.

Top module: `cfg_spi_port`

## Requirements
- R1: A transaction is a 16-bit instruction word followed by data bytes until chip select rises. In the word, bit 15 = 1 means read and bits 14:0 give the start address. MOSI is sampled on rising SCLK. MISO changes after a rising SCLK and reads 0 while chip select is high or no read data is being shifted.
- R2: The instruction and data bits are shifted MSB-first after reset. Writing 1 to bit 1 or to bit 6 of register 0 selects LSB-first. Register 0 reads back the setting in both bit 1 and bit 6.
- R3: A bit-order change written during a transaction takes effect only from the next transaction. Bytes that follow it in the same transaction still use the old order.
- R4: When bit 2 or bit 5 of register 0 is 0 (the reset value), the address decrements after each data byte. When either is 1, the address increments. Register 0 reads back the setting in both bit 2 and bit 5. Bits 4:3 and 7 read 0.
- R5: Writing a byte with bit 0 or bit 7 set to register 0 is a soft reset. It returns register 0 and the power mode to 0, ends the transaction in progress, and reads back as 0.
- R6: After a soft reset, `boot_busy` is high for BOOT_CYCLES clock cycles. During that time every write is ignored, and reads still return data.
- R7: Writing 1 to bit 1 of register 1 produces exactly one clock cycle of `dp_reset_pulse`. Writing 0 produces none. Register 1 always reads 0.
- R8: Register 2 holds the channel power mode in bits 1:0 (00 normal, 10 standby, 11 power-down). It resets to 00, is driven on `power_mode`, and reads back with bits 7:2 at 0.
- R9: Registers 3, 4 and 5 are read-only and return CHIP_TYPE, CHIP_ID[7:0] and CHIP_ID[15:8]. Writes to them have no effect.
- R10: A write to any address above 5 has no effect, and a read from such an address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_csn | input | 1 | Chip select, active low |
| spi_sclk | input | 1 | Serial clock, idle low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial read data to the host |
| power_mode | output | 2 | Channel power mode field |
| dp_reset_pulse | output | 1 | One-cycle datapath reset strobe |
| boot_busy | output | 1 | High while the post-reset boot wait runs |

## Verification
The hardest case to reach is a bit-order change in the middle of a stream. It can be seen only when the same transaction carries more bytes after the configuration byte. The stimulus first turns on ascending addressing. It then sends one MSB-first stream that switches to LSB-first and carries a power-mode byte whose mirror image decodes to a different mode. Only a late switch leaves the power mode correct. A further case writes during the boot wait and reads while the wait is still running, so the bench shows that writes are blocked and reads are not.

// File: rtl/cfg_spi_pkg.sv
package cfg_spi_pkg;

  localparam int unsigned ADDR_W = 15;

  localparam logic [ADDR_W-1:0] A_CFG  = 15'd0;
  localparam logic [ADDR_W-1:0] A_DPR  = 15'd1;
  localparam logic [ADDR_W-1:0] A_PWR  = 15'd2;
  localparam logic [ADDR_W-1:0] A_TYPE = 15'd3;
  localparam logic [ADDR_W-1:0] A_IDLO = 15'd4;
  localparam logic [ADDR_W-1:0] A_IDHI = 15'd5;

  typedef enum logic [1:0] {ST_IDLE, ST_INSTR, ST_DATA, ST_HOLD} port_state_e;

  // shift one serial bit into the instruction word
  function automatic logic [15:0] push16(logic [15:0] w, logic b, logic lsb);
    return lsb ? {b, w[15:1]} : {w[14:0], b};
  endfunction

  // shift one serial bit into a data byte
  function automatic logic [7:0] push8(logic [7:0] w, logic b, logic lsb);
    return lsb ? {b, w[7:1]} : {w[6:0], b};
  endfunction

  function automatic logic [ADDR_W-1:0] step_addr(logic [ADDR_W-1:0] a, logic up);
    return up ? a + 1'b1 : a - 1'b1;
  endfunction

  // read image of the configuration byte: both copies, reset bits read 0
  function automatic logic [7:0] cfg_image(logic lsb, logic up);
    return {1'b0, lsb, up, 2'b00, up, lsb, 1'b0};
  endfunction

endpackage

// File: rtl/cfg_spi_sync.sv
module cfg_spi_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic csn_raw,
  input  logic sclk_raw,
  input  logic mosi_raw,
  output logic cs_active,
  output logic sclk_rise,
  output logic mosi_s
);
  localparam logic [2:0] RST_VAL = 3'b001;  // chip select idles high

  logic [2:0] raw;
  logic [2:0] synced;
  logic       sclk_d;

  assign raw = {mosi_raw, sclk_raw, csn_raw};

  for (genvar g = 0; g < 3; g++) begin : g_line
    logic [STAGES-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= {STAGES{RST_VAL[g]}};
      else        q <= {q[STAGES-2:0], raw[g]};
    end
    assign synced[g] = q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_d <= 1'b0;
    else        sclk_d <= synced[1];
  end

  assign cs_active = ~synced[0];
  assign sclk_rise = synced[1] & ~sclk_d & cs_active;
  assign mosi_s    = synced[2];
endmodule

// File: rtl/cfg_spi_regbank.sv
module cfg_spi_regbank
  import cfg_spi_pkg::*;
#(
  parameter int unsigned BOOT_CYCLES = 625000,
  parameter logic [7:0]  CHIP_TYPE   = 8'h03,
  parameter logic [15:0] CHIP_ID     = 16'h00DE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_req,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              lsb_first,
  output logic              addr_up,
  output logic [1:0]        power_mode,
  output logic              dp_reset_pulse,
  output logic              boot_busy,
  output logic              wr_fire,
  output logic              srst_fire
);
  localparam int unsigned CNT_W = (BOOT_CYCLES < 2) ? 1 : $clog2(BOOT_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BOOT_CYCLES);

  logic [CNT_W-1:0] boot_cnt;

  assign boot_busy = (boot_cnt != '0);
  assign wr_fire   = wr_req & ~boot_busy;
  assign srst_fire = wr_fire & (wr_addr == A_CFG) & (wr_data[0] | wr_data[7]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lsb_first      <= 1'b0;
      addr_up        <= 1'b0;
      power_mode     <= 2'b00;
      dp_reset_pulse <= 1'b0;
      boot_cnt       <= '0;
    end else if (srst_fire) begin
      lsb_first      <= 1'b0;
      addr_up        <= 1'b0;
      power_mode     <= 2'b00;
      dp_reset_pulse <= 1'b0;
      boot_cnt       <= CNT_LOAD;
    end else begin
      dp_reset_pulse <= wr_fire & (wr_addr == A_DPR) & wr_data[1];
      if (boot_busy) boot_cnt <= boot_cnt - 1'b1;
      if (wr_fire && wr_addr == A_CFG) begin
        lsb_first <= wr_data[1] | wr_data[6];
        addr_up   <= wr_data[2] | wr_data[5];
      end
      if (wr_fire && wr_addr == A_PWR) power_mode <= wr_data[1:0];
    end
  end

  always_comb begin
    unique case (rd_addr)
      A_CFG:   rd_data = cfg_image(lsb_first, addr_up);
      A_PWR:   rd_data = {6'd0, power_mode};
      A_TYPE:  rd_data = CHIP_TYPE;
      A_IDLO:  rd_data = CHIP_ID[7:0];
      A_IDHI:  rd_data = CHIP_ID[15:8];
      default: rd_data = 8'h00;
    endcase
  end
endmodule

// File: rtl/cfg_spi_port.sv
module cfg_spi_port
  import cfg_spi_pkg::*;
#(
  parameter int unsigned BOOT_CYCLES = 625000,
  parameter logic [7:0]  CHIP_TYPE   = 8'h03,
  parameter logic [15:0] CHIP_ID     = 16'h00DE,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       spi_csn,
  input  logic       spi_sclk,
  input  logic       spi_mosi,
  output logic       spi_miso,
  output logic [1:0] power_mode,
  output logic       dp_reset_pulse,
  output logic       boot_busy
);
  // named internal events
  logic cs_active, sclk_rise, mosi_s;
  logic instr_done, byte_done, wr_req, wr_fire, srst_fire;
  logic lsb_first, addr_up;

  port_state_e       state;
  logic [3:0]        bit_cnt;
  logic [15:0]       instr_sr;
  logic [7:0]        data_sr;
  logic              rw_q, txn_lsb, txn_up;
  logic [ADDR_W-1:0] cur_addr;
  logic [7:0]        rd_byte;

  logic [15:0]       instr_next;
  logic [7:0]        byte_next;
  logic [ADDR_W-1:0] next_addr, rd_addr;
  logic [7:0]        rd_data;
  logic [2:0]        tx_idx;

  cfg_spi_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .csn_raw(spi_csn), .sclk_raw(spi_sclk), .mosi_raw(spi_mosi),
    .cs_active(cs_active), .sclk_rise(sclk_rise), .mosi_s(mosi_s)
  );

  assign instr_next = push16(instr_sr, mosi_s, txn_lsb);
  assign byte_next  = push8(data_sr, mosi_s, txn_lsb);
  assign instr_done = (state == ST_INSTR) & sclk_rise & (bit_cnt == 4'd15);
  assign byte_done  = (state == ST_DATA) & sclk_rise & (bit_cnt[2:0] == 3'd7);
  assign wr_req     = byte_done & ~rw_q;
  assign next_addr  = step_addr(cur_addr, txn_up);
  assign rd_addr    = instr_done ? instr_next[ADDR_W-1:0] : next_addr;

  cfg_spi_regbank #(
    .BOOT_CYCLES(BOOT_CYCLES), .CHIP_TYPE(CHIP_TYPE), .CHIP_ID(CHIP_ID)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_req(wr_req), .wr_addr(cur_addr), .wr_data(byte_next),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .lsb_first(lsb_first), .addr_up(addr_up),
    .power_mode(power_mode), .dp_reset_pulse(dp_reset_pulse),
    .boot_busy(boot_busy), .wr_fire(wr_fire), .srst_fire(srst_fire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      bit_cnt  <= '0;
      instr_sr <= '0;
      data_sr  <= '0;
      rw_q     <= 1'b0;
      txn_lsb  <= 1'b0;
      txn_up   <= 1'b0;
      cur_addr <= '0;
      rd_byte  <= '0;
    end else if (!cs_active) begin
      // settings are captured while idle, frozen for the whole transaction
      state   <= ST_IDLE;
      txn_lsb <= lsb_first;
      txn_up  <= addr_up;
    end else if (srst_fire) begin
      state <= ST_HOLD;
    end else begin
      unique case (state)
        ST_IDLE: begin
          state    <= ST_INSTR;
          bit_cnt  <= '0;
          instr_sr <= '0;
        end
        ST_INSTR: if (sclk_rise) begin
          instr_sr <= instr_next;
          bit_cnt  <= bit_cnt + 1'b1;
          if (instr_done) begin
            rw_q     <= instr_next[15];
            cur_addr <= instr_next[ADDR_W-1:0];
            rd_byte  <= rd_data;
            bit_cnt  <= '0;
            state    <= ST_DATA;
          end
        end
        ST_DATA: if (sclk_rise) begin
          data_sr <= byte_next;
          bit_cnt <= bit_cnt + 1'b1;
          if (byte_done) begin
            bit_cnt  <= '0;
            cur_addr <= next_addr;
            rd_byte  <= rd_data;
          end
        end
        default: state <= ST_HOLD;
      endcase
    end
  end

  assign tx_idx   = txn_lsb ? bit_cnt[2:0] : ~bit_cnt[2:0];
  assign spi_miso = cs_active & (state == ST_DATA) & rw_q & rd_byte[tx_idx];
endmodule

// File: rtl/cfg_spi_chk.sv
module cfg_spi_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_active,
  input logic       txn_lsb,
  input logic       srst_fire,
  input logic       spi_miso,
  input logic [1:0] power_mode,
  input logic       dp_reset_pulse,
  input logic       boot_busy
);
  p_order_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_active && $past(cs_active)) |-> $stable(txn_lsb));

  p_miso_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_active |-> !spi_miso);

  p_defaults_on_srst_r5: assert property (@(posedge clk) disable iff (!rst_n)
    srst_fire |=> (power_mode == 2'b00));

  p_busy_on_srst_r6: assert property (@(posedge clk) disable iff (!rst_n)
    srst_fire |=> boot_busy);

  p_busy_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_busy && $past(boot_busy)) |-> $stable(power_mode));

  p_single_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dp_reset_pulse |=> !dp_reset_pulse);
endmodule

bind cfg_spi_port cfg_spi_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_active(cs_active), .txn_lsb(txn_lsb),
  .srst_fire(srst_fire), .spi_miso(spi_miso), .power_mode(power_mode),
  .dp_reset_pulse(dp_reset_pulse), .boot_busy(boot_busy)
);

// File: tb/sim_cfg_spi_port.sv
`timescale 1ns/1ps
module sim_cfg_spi_port;
  localparam int unsigned BOOT = 600;
  localparam logic [15:0] ID = 16'h37DE;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic csn = 1'b1, sclk = 1'b0, mosi = 1'b0;
  logic miso, dp_pulse, busy;
  logic [1:0] pmode;

  int checks = 0;
  int errors = 0;
  int dp_cnt = 0;
  logic [7:0] tx_buf [4];
  logic [7:0] rx_buf [4];

  always #4 clk = ~clk;

  cfg_spi_port #(.BOOT_CYCLES(BOOT), .CHIP_TYPE(8'h03), .CHIP_ID(ID)) u0 (
    .clk(clk), .rst_n(rst_n), .spi_csn(csn), .spi_sclk(sclk), .spi_mosi(mosi),
    .spi_miso(miso), .power_mode(pmode), .dp_reset_pulse(dp_pulse), .boot_busy(busy)
  );

  always @(posedge clk) if (dp_pulse) dp_cnt <= dp_cnt + 1;

  // {rw, req, addr, wdata, expected}
  localparam int NV = 14;
  localparam logic [31:0] VEC [NV] = '{
    {1'b0, 7'd8,  8'd2, 8'h03, 8'h00},  // R8 write power mode 11
    {1'b1, 7'd8,  8'd2, 8'h00, 8'h03},  // R8 R1 read back
    {1'b0, 7'd8,  8'd2, 8'h02, 8'h00},  // R8 standby
    {1'b1, 7'd8,  8'd2, 8'h00, 8'h02},  // R8
    {1'b1, 7'd9,  8'd3, 8'h00, 8'h03},  // R9 type
    {1'b1, 7'd9,  8'd4, 8'h00, 8'hDE},  // R9 id low
    {1'b1, 7'd9,  8'd5, 8'h00, 8'h37},  // R9 id high
    {1'b0, 7'd9,  8'd3, 8'hFF, 8'h00},  // R9 write to read-only
    {1'b1, 7'd9,  8'd3, 8'h00, 8'h03},  // R9 unchanged
    {1'b0, 7'd10, 8'd9, 8'h55, 8'h00},  // R10 unmapped write
    {1'b1, 7'd10, 8'd9, 8'h00, 8'h00},  // R10 unmapped read
    {1'b0, 7'd7,  8'd1, 8'h02, 8'h00},  // R7 strobe
    {1'b1, 7'd7,  8'd1, 8'h00, 8'h00},  // R7 reads 0
    {1'b0, 7'd8,  8'd2, 8'h00, 8'h00}   // R8 back to normal
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic spi_bit(input logic b, output logic s);
    mosi = b;
    repeat (4) @(negedge clk);
    s = miso;
    sclk = 1'b1;
    repeat (4) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic spi_txn(input logic lsb, input logic rd, input logic [14:0] addr, input int n);
    logic [15:0] w;
    logic s;
    w = {rd, addr};
    @(negedge clk);
    csn = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 16; i++) spi_bit(lsb ? w[i] : w[15-i], s);
    for (int k = 0; k < n; k++)
      for (int i = 0; i < 8; i++) begin
        spi_bit(tx_buf[k][lsb ? i : 7-i], s);
        rx_buf[k][lsb ? i : 7-i] = s;
      end
    repeat (4) @(negedge clk);
    csn = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic wr1(input logic lsb, input logic [14:0] a, input logic [7:0] d);
    tx_buf[0] = d;
    spi_txn(lsb, 1'b0, a, 1);
  endtask

  task automatic rd1(input logic lsb, input logic [14:0] a);
    tx_buf[0] = 8'h00;
    spi_txn(lsb, 1'b1, a, 1);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    int c0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // reset state
    chk("R8 reset power mode", 32'(pmode), 32'd0);
    chk("R6 reset busy", 32'(busy), 32'd0);
    chk("R7 reset strobe", 32'(dp_pulse), 32'd0);
    chk("R1 reset miso", 32'(miso), 32'd0);
    rd1(0, 15'd0);
    chk("R2 R4 reset config", 32'(rx_buf[0]), 32'h00);

    // vector table, MSB-first, single bytes
    for (int v = 0; v < NV; v++) begin
      if (VEC[v][31]) begin
        rd1(0, 15'(VEC[v][23:16]));
        chk($sformatf("R%0d vector %0d", VEC[v][30:24], v), 32'(rx_buf[0]), 32'(VEC[v][7:0]));
      end else begin
        wr1(0, 15'(VEC[v][23:16]), VEC[v][15:8]);
      end
    end
    chk("R8 power mode pin", 32'(pmode), 32'd0);

    // R7: strobe count
    c0 = dp_cnt;
    wr1(0, 15'd1, 8'h02);
    chk("R7 one strobe on 1", 32'(dp_cnt - c0), 32'd1);
    wr1(0, 15'd1, 8'hFD);
    chk("R7 no strobe on 0", 32'(dp_cnt - c0), 32'd1);

    // R4: ascending via bit 2
    wr1(0, 15'd0, 8'h04);
    rd1(0, 15'd0);
    chk("R4 ascend readback", 32'(rx_buf[0]), 32'h24);

    // R3: one MSB-first stream switches to LSB-first, then writes power mode 10
    tx_buf[0] = 8'h02; tx_buf[1] = 8'h00; tx_buf[2] = 8'h02;
    tx_buf[0] = 8'h66;
    spi_txn(0, 1'b0, 15'd0, 3);
    chk("R3 late order switch", 32'(pmode), 32'd2);
    rd1(1, 15'd0);
    chk("R2 LSB-first readback", 32'(rx_buf[0]), 32'h66);
    rd1(1, 15'd2);
    chk("R3 R8 LSB read", 32'(rx_buf[0]), 32'h02);

    // R4: ascending stream read in LSB order
    tx_buf[0] = 0; tx_buf[1] = 0; tx_buf[2] = 0;
    spi_txn(1, 1'b1, 15'd3, 3);
    chk("R4 up byte0", 32'(rx_buf[0]), 32'h03);
    chk("R4 up byte1", 32'(rx_buf[1]), 32'hDE);
    chk("R4 up byte2", 32'(rx_buf[2]), 32'h37);

    // R4 mirror bit 5, sent LSB-first; turns LSB off
    wr1(1, 15'd0, 8'h20);
    rd1(0, 15'd0);
    chk("R4 mirror bit5", 32'(rx_buf[0]), 32'h24);
    wr1(0, 15'd0, 8'h00);
    tx_buf[0] = 0; tx_buf[1] = 0; tx_buf[2] = 0;
    spi_txn(0, 1'b1, 15'd5, 3);
    chk("R4 down byte0", 32'(rx_buf[0]), 32'h37);
    chk("R4 down byte1", 32'(rx_buf[1]), 32'hDE);
    chk("R4 down byte2", 32'(rx_buf[2]), 32'h03);

    // R2 mirror bit 6
    wr1(0, 15'd0, 8'h40);
    rd1(1, 15'd0);
    chk("R2 mirror bit6", 32'(rx_buf[0]), 32'h42);

    // R5 via bit 7, sent LSB-first
    wr1(1, 15'd2, 8'h03);
    chk("R8 power-down pin", 32'(pmode), 32'd3);
    wr1(1, 15'd0, 8'h80);
    chk("R5 bit7 clears power mode", 32'(pmode), 32'd0);
    chk("R6 busy after bit7", 32'(busy), 32'd1);
    repeat (BOOT + 20) @(negedge clk);
    rd1(0, 15'd0);
    chk("R5 config cleared MSB", 32'(rx_buf[0]), 32'h00);

    // R5/R6 via bit 0, writes blocked while busy
    wr1(0, 15'd2, 8'h03);
    wr1(0, 15'd0, 8'h01);
    chk("R6 busy after bit0", 32'(busy), 32'd1);
    chk("R5 bit0 clears power mode", 32'(pmode), 32'd0);
    wr1(0, 15'd2, 8'h03);
    chk("R6 write ignored", 32'(pmode), 32'd0);
    rd1(0, 15'd3);
    chk("R6 read during wait", 32'(rx_buf[0]), 32'h03);
    chk("R6 still busy", 32'(busy), 32'd1);
    repeat (BOOT) @(negedge clk);
    chk("R6 busy ends", 32'(busy), 32'd0);
    wr1(0, 15'd2, 8'h02);
    chk("R6 write after wait", 32'(pmode), 32'd2);

    finish_run();
  end
endmodule